// File: doc/BRIEF.md
# Serial-Load Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit multiplying converter. A host sends a code over a three-wire link: a serial clock, a serial data line and an active-low load strobe. Each rising edge of the serial clock moves one data bit into a shift register, most significant bit first. A second register holds the code that drives the converter. While the strobe is low that register passes the shift-register contents through, and while the strobe is high it keeps the code it has.

All of this runs in the system clock domain. The three serial inputs pass through a two-stage synchronizer. The serial clock's rising edge is detected after the synchronizer, and the transparent behaviour of the holding register is built as a synchronous equivalent. The block also registers two side outputs. One is a one-cycle flag raised whenever the held code changes. The other is a signed value that reads the code as offset binary, which is how the code is used in four-quadrant operation.

Top module: `serdac_frontend`

## Requirements
- R1: A synchronous active-high reset sets the held code to 0x000, the bipolar output to -2048 and the change flag low, and it clears the shift register.
- R2: Each rising edge of the synchronized serial clock shifts in one data bit, most significant bit first, so that after 12 edges bit 11 holds the first bit received and bit 0 the last.
- R3: When more than 12 bits are shifted in, the leading extra bits are lost and only the last 12 received remain.
- R4: While the load strobe is high, the held code does not change, even while bits are being shifted.
- R5: While the load strobe is low, the held code follows the shift register, including bits shifted in while the strobe stays low.
- R6: With the strobe low and no serial clock edge, the shift register keeps its value and the held code equals it, so repeated strobes with no new bits leave the code unchanged.
- R7: The change flag is high for exactly one system cycle: the first cycle in which the held code shows a new value. It is low at all other times, including after a load that leaves the code the same.
- R8: The signed 13-bit bipolar output always equals the held code minus 2048: code 0x800 gives 0, 0x000 gives -2048 and 0xFFF gives 2047.
- R9: A serial clock pulse shifts exactly one bit, however many system cycles it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Load strobe, active low and level-sensitive |
| dac_code | output | 12 | Held converter code |
| code_changed | output | 1 | One-cycle pulse when dac_code takes a new value |
| bipolar_val | output | 13 | Signed offset-binary reading of dac_code (code minus 2048) |

## Verification
On every cycle, the assertions check the following: each detected serial edge makes one shift step that takes in the synchronized data bit; the shift register keeps its value when no edge is detected; the held code stays fixed while the strobe is inactive and matches the shift register after any cycle with the strobe active; the change flag matches a difference in the code; and the bipolar output tracks the code. Some behaviour only the bench scenarios can show. These are the end-to-end bit order through the synchronizer, the loss of leading extra bits in an over-long frame, a single shift for a long serial clock pulse, repeated strobes that produce no flag, and the values after reset.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int CODE_W_DEF      = 12;
  localparam int SYNC_STAGES_DEF = 2;

  // Bit positions of the serial inputs inside the synchronizer bus
  localparam int IDX_SCLK = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_LOAD = 2;
  localparam int SER_W    = 3;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              data_s,
  output logic              shift_en,
  output logic [CODE_W-1:0] shreg_q,
  output logic [CODE_W-1:0] shreg_nxt
);
  logic sclk_prev;

  assign shift_en  = sclk_s & ~sclk_prev;
  assign shreg_nxt = shift_en ? {shreg_q[CODE_W-2:0], data_s} : shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      shreg_q   <= '0;
    end else begin
      sclk_prev <= sclk_s;
      shreg_q   <= shreg_nxt;
    end
  end
endmodule

// File: rtl/serdac_holdreg.sv
module serdac_holdreg #(
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_low,
  input  logic [CODE_W-1:0]        shreg_nxt,
  output logic [CODE_W-1:0]        code_q,
  output logic                     changed_q,
  output logic signed [CODE_W:0]   bipolar_q
);
  localparam logic [CODE_W:0] MID = (CODE_W+1)'(1) << (CODE_W-1);
  localparam logic [CODE_W:0] RST_BIP = '0 - MID;

  logic [CODE_W-1:0] code_d;
  logic [CODE_W:0]   bip_d;

  assign code_d = load_low ? shreg_nxt : code_q;
  assign bip_d  = {1'b0, code_d} - MID;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      changed_q <= 1'b0;
      bipolar_q <= RST_BIP;
    end else begin
      code_q    <= code_d;
      changed_q <= (code_d != code_q);
      bipolar_q <= bip_d;
    end
  end
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
  import serdac_pkg::*;
#(
  parameter int CODE_W      = CODE_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_clk,
  input  logic                   ser_data,
  input  logic                   load_n,
  output logic [CODE_W-1:0]      dac_code,
  output logic                   code_changed,
  output logic signed [CODE_W:0] bipolar_val
);
  localparam logic [SER_W-1:0] SER_RST = SER_W'(1) << IDX_LOAD;

  logic [SER_W-1:0]  ser_raw, ser_s;
  logic              sclk_s, data_s, load_low, shift_en;
  logic [CODE_W-1:0] shreg, shreg_nxt;

  assign ser_raw[IDX_SCLK] = ser_clk;
  assign ser_raw[IDX_DATA] = ser_data;
  assign ser_raw[IDX_LOAD] = load_n;

  serdac_sync #(.W(SER_W), .STAGES(SYNC_STAGES), .RST_VAL(SER_RST)) u_sync (
    .clk(clk), .rst(rst), .d(ser_raw), .q(ser_s)
  );

  assign sclk_s   = ser_s[IDX_SCLK];
  assign data_s   = ser_s[IDX_DATA];
  assign load_low = ~ser_s[IDX_LOAD];

  serdac_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .data_s(data_s),
    .shift_en(shift_en), .shreg_q(shreg), .shreg_nxt(shreg_nxt)
  );

  serdac_holdreg #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst(rst), .load_low(load_low), .shreg_nxt(shreg_nxt),
    .code_q(dac_code), .changed_q(code_changed), .bipolar_q(bipolar_val)
  );
endmodule

// File: rtl/serdac_checker.sv
module serdac_checker #(
  parameter int CODE_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   shift_en,
  input logic                   data_s,
  input logic                   load_low,
  input logic [CODE_W-1:0]      shreg,
  input logic [CODE_W-1:0]      dac_code,
  input logic                   code_changed,
  input logic signed [CODE_W:0] bipolar_val
);
  localparam logic [CODE_W:0] MID = (CODE_W+1)'(1) << (CODE_W-1);

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (shreg == {$past(shreg[CODE_W-2:0]), $past(data_s)}));

  assert_no_edge_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(shreg));

  assert_hold_when_high_R4: assert property (@(posedge clk) disable iff (rst)
    !load_low |=> $stable(dac_code));

  assert_follow_when_low_R5: assert property (@(posedge clk) disable iff (rst)
    load_low |=> (dac_code == shreg));

  assert_flag_match_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (code_changed == (dac_code != $past(dac_code))));

  assert_bipolar_R8: assert property (@(posedge clk) disable iff (rst)
    $unsigned(bipolar_val) == (({1'b0, dac_code} - MID)));
endmodule

bind serdac_frontend serdac_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .data_s(data_s),
  .load_low(load_low), .shreg(shreg), .dac_code(dac_code),
  .code_changed(code_changed), .bipolar_val(bipolar_val)
);

// File: tb/tb_serdac_frontend.sv
module tb_serdac_frontend;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, load_n = 1'b1;
  logic [11:0] dac_code;
  logic code_changed;
  logic signed [12:0] bipolar_val;

  int total = 0, bad = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serdac_frontend dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_n(load_n), .dac_code(dac_code), .code_changed(code_changed),
    .bipolar_val(bipolar_val)
  );

  always @(negedge clk) if (code_changed) pulses++;

  localparam logic [11:0] VEC [6] = '{12'hA5C, 12'h800, 12'h800, 12'hFFF, 12'h000, 12'h7FF};

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int high_cyc);
    ser_data = b;
    ser_clk  = 1'b0;
    wait_cyc(3);
    ser_clk  = 1'b1;
    wait_cyc(high_cyc);
    ser_clk  = 1'b0;
    wait_cyc(2);
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i], 3);
    wait_cyc(4);
  endtask

  task automatic strobe();
    load_n = 1'b0;
    wait_cyc(4);
    load_n = 1'b1;
    wait_cyc(5);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev;
    logic [11:0] rv;
    wait_cyc(4);
    // R1 reset values
    check("R1 code", dac_code, 0);
    check("R1 bipolar", bipolar_val, -2048);
    check("R1 flag", code_changed, 0);
    rst = 1'b0;
    wait_cyc(2);
    pulses = 0;
    strobe();
    check("R1 shreg cleared", dac_code, 0);
    check("R1 no pulse", pulses, 0);

    prev = 12'h000;
    for (int k = 0; k < 6; k++) begin
      pulses = 0;
      send_word({4'h0, VEC[k]}, 12);
      check("R4 hold while shifting", dac_code, prev);
      check("R4 no flag while shifting", pulses, 0);
      strobe();
      check("R2 msb-first word", dac_code, VEC[k]);
      check("R8 bipolar", bipolar_val, int'(VEC[k]) - 2048);
      check("R7 pulse count", pulses, (VEC[k] != prev) ? 1 : 0);
      prev = VEC[k];
    end

    // R8 fixed points
    send_word(16'h0800, 12); strobe();
    check("R8 mid to zero", bipolar_val, 0);
    send_word(16'h0FFF, 12); strobe();
    check("R8 top", bipolar_val, 2047);
    send_word(16'h0000, 12); strobe();
    check("R8 bottom", bipolar_val, -2048);

    // R3 extra leading bits dropped
    send_word(16'hF123, 16);
    strobe();
    check("R3 last 12 kept", dac_code, 12'h123);

    // R6 strobe again with no new bits
    pulses = 0;
    strobe();
    strobe();
    check("R6 code unchanged", dac_code, 12'h123);
    check("R6 no flag", pulses, 0);

    // R5 transparent while strobe held low; R9 long pulse shifts once
    rv = 12'h123;
    load_n = 1'b0;
    wait_cyc(5);
    check("R5 follows when low", dac_code, rv);
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = (i % 2 == 0);
      pulses = 0;
      send_bit(b, (i == 1) ? 20 : 3);
      wait_cyc(2);
      rv = {rv[10:0], b};
      check((i == 1) ? "R9 one shift per long pulse" : "R5 follow new bit", dac_code, rv);
      check("R7 one pulse per change", pulses, 1);
    end
    load_n = 1'b1;
    wait_cyc(5);
    send_word(16'h0ABC, 12);
    check("R4 hold after release", dac_code, rv);

    // R1 reset mid-operation
    rst = 1'b1;
    wait_cyc(3);
    check("R1 code after reset", dac_code, 0);
    check("R1 bipolar after reset", bipolar_val, -2048);
    rst = 1'b0;
    wait_cyc(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule